// File: doc/BRIEF.md
# Eight-bit flag-producing ALU

This block is a purely combinational arithmetic/logic unit. It accepts two operands, `op_b` and `op_c`, and a 3-bit function code. From these it produces one result word and three condition outputs: carry, sign and zero.

Inside the block, a ripple-carry adder, a bitwise logic unit and a left-rotate unit all compute at the same time. A decoder turns the function code into eight one-hot lane enables. Only the enabled lane contributes to the result.

The highest code enables an empty lane, so it acts as a no-operation and the result reads as all zeros. The sign and zero flags are derived from whichever result is selected. The carry output is reported only by the two adder codes.

The block has no storage, so no handshake applies. A new result and new flags follow any change of the inputs in the same cycle.

Top module: `flag_alu`

## Requirements
- R1: Code 3'b000 produces res = (op_b + op_c) mod 256, with carry-in 0. carry equals the carry out of bit 7.
- R2: Code 3'b001 produces res = (op_b + 1) mod 256. carry is 1 exactly when op_b is 8'hFF.
- R3: Code 3'b010 produces op_b AND op_c. Code 3'b011 produces op_b OR op_c. Code 3'b100 produces op_b XOR op_c.
- R4: Code 3'b101 produces the bitwise complement of op_b, and op_c has no effect.
- R5: Code 3'b110 rotates op_b left by one bit position. res[0] takes op_b[7], and op_c has no effect.
- R6: Code 3'b111 enables no unit. res reads 8'h00 for every operand value.
- R7: zero is 1 exactly when all bits of res are 0.
- R8: sign equals res[7].
- R9: carry is 0 for every code other than 3'b000 and 3'b001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_b | input | 8 | First operand; the only operand used by the increment, complement and rotate codes |
| op_c | input | 8 | Second operand |
| func | input | 3 | Function code |
| res | output | 8 | Selected result |
| carry | output | 1 | Adder carry out for codes 000 and 001, otherwise 0 |
| sign | output | 1 | Bit 7 of res |
| zero | output | 1 | High when res is all zeros |

## Verification
The checker's assertions evaluate only when all three inputs are known 0/1 values, and they accept any of the eight function codes. The stimulus therefore always drives fully defined operands and codes. It sweeps every code against every pair of operand values, so it covers the corner cases inside that space: the wrap at 8'hFF, a rotate with bit 7 set, and operands that are ignored under the single-operand codes.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int FUNC_W = 3;
  localparam int N_LANE = 2 ** FUNC_W;

  typedef enum logic [FUNC_W-1:0] {
    FN_ADD = 3'b000,
    FN_INC = 3'b001,
    FN_AND = 3'b010,
    FN_OR  = 3'b011,
    FN_XOR = 3'b100,
    FN_NOT = 3'b101,
    FN_ROL = 3'b110,
    FN_NOP = 3'b111
  } alu_fn_e;
endpackage

// File: rtl/alu_lane_decode.sv
module alu_lane_decode
  import flag_alu_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  output logic [N_LANE-1:0] lane_en
);
  always_comb begin
    lane_en       = '0;
    lane_en[func] = 1'b1;
  end
endmodule

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] cy;
  assign cy[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = a[i] ^ b[i] ^ cy[i];
    assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
  end

  assign cout = cy[W];
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] xor_o,
  output logic [W-1:0] not_o,
  output logic [W-1:0] rol_o
);
  assign and_o = a & b;
  assign or_o  = a | b;
  assign xor_o = a ^ b;
  assign not_o = ~a;

  for (genvar i = 0; i < W; i++) begin : g_rol
    if (i == 0) begin : g_wrap
      assign rol_o[0] = a[W-1];
    end else begin : g_shift
      assign rol_o[i] = a[i-1];
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]      op_b,
  input  logic [W-1:0]      op_c,
  input  logic [FUNC_W-1:0] func,
  output logic [W-1:0]      res,
  output logic              carry,
  output logic              sign,
  output logic              zero
);
  logic [N_LANE-1:0] unit_en;
  logic [W-1:0]      addend, sum_v, and_v, or_v, xor_v, not_v, rol_v;
  logic              add_cout;
  logic [W-1:0]      lane [N_LANE];

  alu_lane_decode u_dec (
    .func    (func),
    .lane_en (unit_en)
  );

  // Increment reuses the adder: zero addend, carry-in of one.
  assign addend = unit_en[FN_INC] ? '0 : op_c;

  alu_ripple_add #(.W(W)) u_add (
    .a    (op_b),
    .b    (addend),
    .cin  (unit_en[FN_INC]),
    .sum  (sum_v),
    .cout (add_cout)
  );

  alu_bitwise #(.W(W)) u_bit (
    .a     (op_b),
    .b     (op_c),
    .and_o (and_v),
    .or_o  (or_v),
    .xor_o (xor_v),
    .not_o (not_v),
    .rol_o (rol_v)
  );

  assign lane[FN_ADD] = sum_v;
  assign lane[FN_INC] = sum_v;
  assign lane[FN_AND] = and_v;
  assign lane[FN_OR]  = or_v;
  assign lane[FN_XOR] = xor_v;
  assign lane[FN_NOT] = not_v;
  assign lane[FN_ROL] = rol_v;
  assign lane[FN_NOP] = '0;

  // AND-OR result bus: each enabled lane ORs its word in.
  always_comb begin
    res = '0;
    for (int k = 0; k < N_LANE; k++) begin
      res = res | (lane[k] & {W{unit_en[k]}});
    end
  end

  assign carry = add_cout & (unit_en[FN_ADD] | unit_en[FN_INC]);
  assign sign  = res[W-1];
  assign zero  = ~|res;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] op_b,
  input logic [W-1:0] op_c,
  input logic [2:0]   func,
  input logic [W-1:0] res,
  input logic         carry,
  input logic         sign,
  input logic         zero,
  input logic [7:0]   unit_en
);
  always_comb begin
    if (!$isunknown({op_b, op_c, func})) begin
      AST_ZERO_FLAG: assert (zero == (res == '0)) else $error("zero flag mismatch"); // R7
      AST_SIGN_FLAG: assert (sign == res[W-1]) else $error("sign flag mismatch"); // R8
      AST_CARRY_QUIET: assert (func < 3'd2 || !carry) else $error("carry outside adder codes"); // R9
      AST_NOP_CLEAR: assert (func != 3'd7 || res == '0) else $error("nop result not zero"); // R6
      AST_ROTATE_WRAP: assert (func != 3'd6 || res == {op_b[W-2:0], op_b[W-1]}) else $error("rotate wrong"); // R5
      AST_ONE_LANE: assert ($onehot(unit_en)) else $error("lane enable not one-hot"); // R6
      AST_INC_CARRY: assert (func != 3'd1 || carry == (op_b == '1)) else $error("inc carry wrong"); // R2
    end
  end
endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
  .op_b    (op_b),
  .op_c    (op_c),
  .func    (func),
  .res     (res),
  .carry   (carry),
  .sign    (sign),
  .zero    (zero),
  .unit_en (unit_en)
);

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] op_b = '0, op_c = '0;
  logic [2:0] func = '0;
  logic [7:0] res;
  logic       carry, sign, zero;
  int         errors = 0;
  int         checks = 0;
  int         cyc = 0;

  always #2 clk = ~clk;

  flag_alu u_flag_alu (
    .op_b  (op_b),
    .op_c  (op_c),
    .func  (func),
    .res   (res),
    .carry (carry),
    .sign  (sign),
    .zero  (zero)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s code=%0d b=%02h c=%02h got=%0h exp=%0h", req, func, op_b, op_c, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // Idle inputs (add of zeros): result zero, zero flag set (R1, R7).
    #1;
    chk("R1", res, 0);
    chk("R7", zero, 1);
    for (int f = 0; f < 8; f++) begin
      for (int b = 0; b < 256; b++) begin
        for (int c = 0; c < 256; c++) begin
          int    full, er, ec;
          string rq;
          func = 3'(f);
          op_b = 8'(b);
          op_c = 8'(c);
          ec   = 0;
          case (f)
            0: begin full = b + c; rq = "R1"; ec = full >> 8; end
            1: begin full = b + 1; rq = "R2"; ec = full >> 8; end
            2: begin full = b & c; rq = "R3"; end
            3: begin full = b | c; rq = "R3"; end
            4: begin full = b ^ c; rq = "R3"; end
            5: begin full = 255 - b; rq = "R4"; end
            6: begin full = ((b << 1) | (b >> 7)); rq = "R5"; end
            default: begin full = 0; rq = "R6"; end
          endcase
          er = full & 255;
          #1;
          chk(rq, res, er);
          chk((f < 2) ? rq : "R9", carry, ec);
          chk("R7", zero, (er == 0) ? 1 : 0);
          chk("R8", sign, er >> 7);
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule